// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the configuration that hides system-management memory from ordinary CPU traffic and steers every memory access to one of three destinations: DRAM, the bus (the legacy video path and everything above low memory), or a black hole that returns all ones and drops writes. It covers three regions: the 128 KiB legacy window at 0x000A0000, a 128 KiB high alias at 0xFEDA0000 that maps onto the same DRAM, and a TSEG window that ends at the top of low memory. Each access is classified on its address and on a flag that says whether the CPU is in system-management mode (SMM), so normal code and SMM code see two independent views.

Software programs the block through a byte-wide configuration port with four byte addresses. There is a control byte, an extended control byte and a 16-bit extended TSEG size word. A sticky lock bit closes the open window and freezes both control bytes until reset. The size word carries a query handshake: reset loads the query code, and when software writes that code back the word answers with the configured extended size in MiB. Routing is combinational from the register state, so a configuration write changes the routing of accesses presented after the next clock edge.

Top module: `smtc_ctrl`

## Requirements
- R1: After reset the control byte (address 0) and the extended control byte (address 1) read 0x00. The size word (address 2 low byte, address 3 high byte) reads 0xFFFF when EXT_MIB is non-zero and 0x0000 otherwise.
- R2: Control byte fields are bit 0 open, bit 1 lock and bit 2 SMM global enable. Extended control fields are bit 0 TSEG enable, bits 2:1 TSEG size code and bit 7 high-alias enable. All other bits read 0 and ignore writes.
- R3: A write that leaves the lock bit set clears the open bit, in the same write as well. From then until reset, writes to either control byte have no effect.
- R4: In the normal view the legacy window goes to DRAM when open=1 and high=0, and to the bus in every other case.
- R5: In the normal view the high alias window goes to DRAM only when open=1 and high=1, and to the bus otherwise.
- R6: In the SMM view, with global=1, the legacy window goes to DRAM when high=0 and the high alias goes to DRAM when high=1. Any window not claimed this way routes as in the normal view.
- R7: The TSEG size is 0 when TSEG enable is 0. Otherwise size codes 0, 1 and 2 give 1, 2 and 8 MiB, and code 3 gives EXT_MIB MiB.
- R8: TSEG covers [TOP_LOW - size, TOP_LOW). Normal accesses there go to the black hole, and SMM accesses go to DRAM.
- R9: Target codes are 0 DRAM, 1 bus, 2 black hole and 3 reject. A black-hole access whose byte count lies outside 1 to 4 is rejected. acc_hole_data is 0xFFFFFFFF exactly when the target is the black hole, and 0 otherwise.
- R10: A write that makes the size word equal 0xFFFF replaces it with EXT_MIB when EXT_MIB is non-zero. Any other value is stored as written, and the lock does not affect these writes.
- R11: Addresses outside all three windows go to DRAM below TOP_LOW and to the bus at or above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 2 | Configuration write byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 2 | Configuration read byte address |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_addr | input | 32 | Address of the memory access |
| acc_smm | input | 1 | Access issued in system-management mode |
| acc_bytes | input | 3 | Byte count of the access |
| acc_target | output | 2 | Destination code of the access |
| acc_hole_data | output | 32 | Read data returned by the black hole |

## Verification
Accesses are aimed at the two 128 KiB windows, at a band around the top of low memory and at random addresses. Each lands in both views under random open, high-enable, global-enable and TSEG settings, which separates the two views and the precedence of TSEG over the default DRAM/bus split. Directed probes sit one byte inside and one byte outside every window edge and the TSEG floor for each size code, and they expose off-by-one bounds and wrong size decoding. Byte counts of 0 and 5 separate black-hole rejection from normal routing. A late lock phase shows that the open bit falls and that later control writes leave both read-back values and routing unchanged.

// File: rtl/smtc_pkg.sv
package smtc_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned SIZE_W    = 16;

    localparam logic [ADDR_W-1:0] LEGACY_BASE = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] ALIAS_BASE  = 32'hFEDA_0000;
    localparam logic [ADDR_W-1:0] WIN_BYTES   = 32'h0002_0000;

    localparam logic [1:0] CFG_CTL  = 2'd0;
    localparam logic [1:0] CFG_ECTL = 2'd1;
    localparam logic [1:0] CFG_XLO  = 2'd2;
    localparam logic [1:0] CFG_XHI  = 2'd3;

    localparam logic [7:0] CTL_MASK_OPEN    = 8'h07;
    localparam logic [7:0] CTL_MASK_LOCKED  = 8'h00;
    localparam logic [7:0] ECTL_MASK_OPEN   = 8'h87;
    localparam logic [7:0] ECTL_MASK_LOCKED = 8'h00;

    localparam logic [SIZE_W-1:0] SIZE_QUERY = 16'hFFFF;

    typedef enum logic [1:0] {
        TGT_DRAM   = 2'd0,
        TGT_BUS    = 2'd1,
        TGT_HOLE   = 2'd2,
        TGT_REJECT = 2'd3
    } target_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       g_en;
        logic       lock;
        logic       open;
    } smram_ctl_t;

    typedef struct packed {
        logic       h_en;
        logic [3:0] rsvd;
        logic [1:0] tsz;
        logic       t_en;
    } smram_ectl_t;

    function automatic logic [7:0] mask_merge(logic [7:0] old_v, logic [7:0] new_v,
                                              logic [7:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    function automatic logic [SIZE_W-1:0] tseg_mib(smram_ectl_t e, logic [SIZE_W-1:0] ext);
        logic [SIZE_W-1:0] r;
        if (!e.t_en) begin
            r = '0;
        end else begin
            case (e.tsz)
                2'd0:    r = 16'd1;
                2'd1:    r = 16'd2;
                2'd2:    r = 16'd8;
                default: r = ext;
            endcase
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] tseg_floor(logic [ADDR_W-1:0] top,
                                                     logic [SIZE_W-1:0] mib);
        logic [ADDR_W+3:0] bytes;
        logic [ADDR_W+3:0] top_w;
        bytes = {mib, 20'b0};
        top_w = {4'b0, top};
        if (bytes > top_w) return '0;
        return top - bytes[ADDR_W-1:0];
    endfunction

    function automatic logic in_win(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base,
                                    logic [ADDR_W-1:0] len);
        return (a >= base) && ((a - base) < len);
    endfunction

endpackage

// File: rtl/smtc_cfg_regs.sv
module smtc_cfg_regs
    import smtc_pkg::*;
#(
    parameter int unsigned EXT_MIB = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [1:0]  waddr,
    input  logic [7:0]  wdata,
    input  logic [1:0]  raddr,
    output logic [7:0]  rdata,
    output smram_ctl_t  ctl,
    output smram_ectl_t ectl
);

    localparam logic [SIZE_W-1:0] EXT_VAL   = SIZE_W'(EXT_MIB);
    localparam logic [SIZE_W-1:0] SIZE_INIT = (EXT_MIB != 0) ? SIZE_QUERY : '0;

    smram_ctl_t        ctl_q, ctl_d;
    smram_ectl_t       ectl_q, ectl_d;
    logic [SIZE_W-1:0] xsz_q, xsz_d;
    logic [7:0]        ctl_msk, ectl_msk;
    logic              xsz_wr;

    assign ctl_msk  = ctl_q.lock ? CTL_MASK_LOCKED  : CTL_MASK_OPEN;
    assign ectl_msk = ctl_q.lock ? ECTL_MASK_LOCKED : ECTL_MASK_OPEN;
    assign xsz_wr   = wr && ((waddr == CFG_XLO) || (waddr == CFG_XHI));

    always_comb begin
        ctl_d  = ctl_q;
        ectl_d = ectl_q;
        xsz_d  = xsz_q;
        if (wr) begin
            case (waddr)
                CFG_CTL:  ctl_d        = smram_ctl_t'(mask_merge(ctl_q, wdata, ctl_msk));
                CFG_ECTL: ectl_d       = smram_ectl_t'(mask_merge(ectl_q, wdata, ectl_msk));
                CFG_XLO:  xsz_d[7:0]   = wdata;
                default:  xsz_d[15:8]  = wdata;
            endcase
        end
        if (ctl_d.lock) begin
            ctl_d.open = 1'b0;
        end
        if ((EXT_MIB != 0) && xsz_wr && (xsz_d == SIZE_QUERY)) begin
            xsz_d = EXT_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ectl_q <= '0;
            xsz_q  <= SIZE_INIT;
        end else begin
            ctl_q  <= ctl_d;
            ectl_q <= ectl_d;
            xsz_q  <= xsz_d;
        end
    end

    always_comb begin
        case (raddr)
            CFG_CTL:  rdata = ctl_q;
            CFG_ECTL: rdata = ectl_q;
            CFG_XLO:  rdata = xsz_q[7:0];
            default:  rdata = xsz_q[15:8];
        endcase
    end

    assign ctl  = ctl_q;
    assign ectl = ectl_q;

    // R3: the lock survives every later write
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |=> ctl_q.lock);

    // R3: a locked window is never open
    a_r3_closed_when_locked: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock |-> !ctl_q.open);

    // R3: extended control frozen once locked
    a_r3_ectl_frozen: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.lock && wr && (waddr == CFG_ECTL)) |=> $stable(ectl_q));

    // R10: a size word write never leaves the query code behind
    a_r10_query_answered: assert property (@(posedge clk) disable iff (rst)
        ((EXT_MIB != 0) && xsz_wr) |=> (xsz_q != SIZE_QUERY));

endmodule

// File: rtl/smtc_tseg_calc.sv
module smtc_tseg_calc
    import smtc_pkg::*;
#(
    parameter logic [31:0] TOP_LOW = 32'h8000_0000,
    parameter int unsigned EXT_MIB = 16
) (
    input  smram_ectl_t        ectl,
    output logic               tseg_live,
    output logic [ADDR_W-1:0]  tseg_base
);

    localparam logic [SIZE_W-1:0] EXT_VAL = SIZE_W'(EXT_MIB);

    logic [SIZE_W-1:0] mib;

    assign mib       = tseg_mib(ectl, EXT_VAL);
    assign tseg_live = (mib != '0);
    assign tseg_base = tseg_floor(TOP_LOW, mib);

endmodule

// File: rtl/smtc_route.sv
module smtc_route
    import smtc_pkg::*;
#(
    parameter logic [31:0] TOP_LOW = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              smm,
    input  logic [2:0]        bytes,
    input  smram_ctl_t        ctl,
    input  smram_ectl_t       ectl,
    input  logic              tseg_live,
    input  logic [ADDR_W-1:0] tseg_base,
    output target_e           target
);

    logic    hit_low, hit_alias, hit_tseg, size_ok;
    target_e plain_t, normal_t, smm_t, raw_t;

    assign hit_low   = in_win(addr, LEGACY_BASE, WIN_BYTES);
    assign hit_alias = in_win(addr, ALIAS_BASE, WIN_BYTES);
    assign hit_tseg  = tseg_live && (addr >= tseg_base) && (addr < TOP_LOW);
    assign size_ok   = (bytes >= 3'd1) && (bytes <= 3'd4);
    assign plain_t   = (addr < TOP_LOW) ? TGT_DRAM : TGT_BUS;

    // normal-mode view
    always_comb begin
        if (hit_tseg) begin
            normal_t = TGT_HOLE;
        end else if (hit_low) begin
            normal_t = (ctl.open && !ectl.h_en) ? TGT_DRAM : TGT_BUS;
        end else if (hit_alias) begin
            normal_t = (ctl.open && ectl.h_en) ? TGT_DRAM : TGT_BUS;
        end else begin
            normal_t = plain_t;
        end
    end

    // system-management view overlays the normal one
    always_comb begin
        if (hit_tseg) begin
            smm_t = TGT_DRAM;
        end else if (hit_low && ctl.g_en && !ectl.h_en) begin
            smm_t = TGT_DRAM;
        end else if (hit_alias && ctl.g_en && ectl.h_en) begin
            smm_t = TGT_DRAM;
        end else begin
            smm_t = normal_t;
        end
    end

    assign raw_t  = smm ? smm_t : normal_t;
    assign target = ((raw_t == TGT_HOLE) && !size_ok) ? TGT_REJECT : raw_t;

endmodule

// File: rtl/smtc_ctrl.sv
module smtc_ctrl
    import smtc_pkg::*;
#(
    parameter logic [31:0] TOP_LOW = 32'h8000_0000,
    parameter int unsigned EXT_MIB = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_waddr,
    input  logic [7:0]  cfg_wdata,
    input  logic [1:0]  cfg_raddr,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    input  logic [2:0]  acc_bytes,
    output logic [1:0]  acc_target,
    output logic [31:0] acc_hole_data
);

    smram_ctl_t        ctl;
    smram_ectl_t       ectl;
    logic              tseg_live;
    logic [ADDR_W-1:0] tseg_base;
    target_e           tgt;

    smtc_cfg_regs #(.EXT_MIB(EXT_MIB)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .ctl   (ctl),
        .ectl  (ectl)
    );

    smtc_tseg_calc #(.TOP_LOW(TOP_LOW), .EXT_MIB(EXT_MIB)) u_tseg (
        .ectl      (ectl),
        .tseg_live (tseg_live),
        .tseg_base (tseg_base)
    );

    smtc_route #(.TOP_LOW(TOP_LOW)) u_route (
        .addr      (acc_addr),
        .smm       (acc_smm),
        .bytes     (acc_bytes),
        .ctl       (ctl),
        .ectl      (ectl),
        .tseg_live (tseg_live),
        .tseg_base (tseg_base),
        .target    (tgt)
    );

    assign acc_target    = tgt;
    assign acc_hole_data = (tgt == TGT_HOLE) ? 32'hFFFF_FFFF : 32'h0;

    // R6: SMM traffic is never swallowed by the black hole
    a_r6_smm_no_hole: assert property (@(posedge clk) disable iff (rst)
        acc_smm |-> (acc_target != 2'd2));

    // R8: normal access inside live TSEG with a legal size hits the hole
    a_r8_tseg_hidden: assert property (@(posedge clk) disable iff (rst)
        (!acc_smm && tseg_live && (acc_addr >= tseg_base) && (acc_addr < TOP_LOW)
         && (acc_bytes >= 3'd1) && (acc_bytes <= 3'd4)) |-> (acc_target == 2'd2));

    // R5: the high alias never reaches DRAM in the normal view while locked shut
    a_r5_alias_closed: assert property (@(posedge clk) disable iff (rst)
        (!acc_smm && !ctl.open && (acc_addr >= ALIAS_BASE)
         && (acc_addr - ALIAS_BASE < WIN_BYTES)) |-> (acc_target == 2'd1));

    // R11: nothing at or above the top of low memory lands in the hole
    a_r11_above_top: assert property (@(posedge clk) disable iff (rst)
        (acc_addr >= TOP_LOW) |-> (acc_target[1] == 1'b0));

endmodule

// File: tb/smtc_ctrl_bench.sv
module smtc_ctrl_bench;

    localparam logic [31:0] TOP = 32'h8000_0000;
    localparam int unsigned EXTM = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [1:0]  cfg_waddr;
    logic [7:0]  cfg_wdata;
    logic [1:0]  cfg_raddr;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr;
    logic        acc_smm;
    logic [2:0]  acc_bytes;
    logic [1:0]  acc_target;
    logic [31:0] acc_hole_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]  m_ctl, m_ectl;
    logic [15:0] m_x;

    always #2.5 clk = ~clk;

    smtc_ctrl #(.TOP_LOW(TOP), .EXT_MIB(EXTM)) u_smtc_ctrl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_bytes(acc_bytes),
        .acc_target(acc_target), .acc_hole_data(acc_hole_data)
    );

    function automatic int size_mib();
        if (!m_ectl[0]) return 0;
        case (m_ectl[2:1])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return EXTM;
        endcase
    endfunction

    function automatic logic [1:0] exp_target(logic [31:0] a, logic smm, logic [2:0] nb);
        longint sz = longint'(size_mib()) * 1048576;
        logic t = (sz != 0) && (longint'(a) >= longint'(TOP) - sz) && (a < TOP);
        logic lo = (a >= 32'h000A_0000) && (a < 32'h000C_0000);
        logic hi = (a >= 32'hFEDA_0000) && (a < 32'hFEDC_0000);
        logic open = m_ctl[0], g = m_ctl[2], h = m_ectl[7];
        logic [1:0] n, r;
        if (t) n = 2'd2;
        else if (lo) n = (open && !h) ? 2'd0 : 2'd1;
        else if (hi) n = (open && h) ? 2'd0 : 2'd1;
        else n = (a < TOP) ? 2'd0 : 2'd1;
        r = n;
        if (smm) begin
            if (t) r = 2'd0;
            else if (lo && g && !h) r = 2'd0;
            else if (hi && g && h) r = 2'd0;
        end
        if (r == 2'd2 && (nb < 3'd1 || nb > 3'd4)) r = 2'd3;
        return r;
    endfunction

    function automatic string tag_of(logic [31:0] a, logic smm, logic [2:0] nb);
        longint sz = longint'(size_mib()) * 1048576;
        if ((sz != 0) && (longint'(a) >= longint'(TOP) - sz) && (a < TOP))
            return (nb < 3'd1 || nb > 3'd4) ? "R9" : "R8";
        if ((a >= 32'h000A_0000) && (a < 32'h000C_0000)) return smm ? "R6" : "R4";
        if ((a >= 32'hFEDA_0000) && (a < 32'hFEDC_0000)) return smm ? "R6" : "R5";
        return "R11";
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (a)
            2'd0: if (!m_ctl[1]) begin
                      m_ctl = (m_ctl & ~8'h07) | (d & 8'h07);
                      if (m_ctl[1]) m_ctl[0] = 1'b0;
                  end
            2'd1: if (!m_ctl[1]) m_ectl = (m_ectl & ~8'h87) | (d & 8'h87);
            2'd2: m_x[7:0] = d;
            default: m_x[15:8] = d;
        endcase
        if (a[1] && m_x == 16'hFFFF && EXTM != 0) m_x = 16'(EXTM);
    endtask

    task automatic rd_check(logic [1:0] a, string req);
        logic [7:0] e;
        cfg_raddr = a;
        #1;
        case (a)
            2'd0: e = m_ctl;
            2'd1: e = m_ectl;
            2'd2: e = m_x[7:0];
            default: e = m_x[15:8];
        endcase
        check(req, $sformatf("readback addr %0d", a), cfg_rdata, e);
    endtask

    task automatic probe(logic [31:0] a, logic smm, logic [2:0] nb, string req);
        logic [1:0] e;
        acc_addr = a; acc_smm = smm; acc_bytes = nb;
        #1;
        e = exp_target(a, smm, nb);
        check(req, $sformatf("target a=%h smm=%0d n=%0d", a, smm, nb), acc_target, e);
        check("R9", "hole data", acc_hole_data, (e == 2'd2) ? 32'hFFFF_FFFF : 32'h0);
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick_addr();
        int unsigned r = $urandom % 6;
        case (r)
            0: return 32'h000A_0000 + ($urandom % 32'h0002_0000);
            1: return 32'hFEDA_0000 + ($urandom % 32'h0002_0000);
            2: return TOP - 1 - ($urandom % 32'h00A0_0000);
            3: return TOP + ($urandom % 32'h0010_0000);
            4: begin
                case ($urandom % 8)
                    0: return 32'h0009_FFFF;
                    1: return 32'h000A_0000;
                    2: return 32'h000B_FFFF;
                    3: return 32'h000C_0000;
                    4: return 32'hFED9_FFFF;
                    5: return 32'hFEDB_FFFF;
                    6: return 32'hFEDC_0000;
                    default: return TOP - 1;
                endcase
            end
            default: return $urandom;
        endcase
    endfunction

    task automatic random_phase(int n, bit allow_lock);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            logic [1:0] a = 2'($urandom % 4);
            if (a == 2'd0 && !allow_lock) d[1] = 1'b0;
            wr(a, d);
            rd_check(a, (a == 2'd0 || a == 2'd1) ? (m_ctl[1] ? "R3" : "R2") : "R10");
            for (int k = 0; k < 4; k++) begin
                logic [31:0] ad = pick_addr();
                logic s = 1'($urandom);
                logic [2:0] nb = (($urandom % 8) == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
                probe(ad, s, nb, tag_of(ad, s, nb));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_wr = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
        acc_addr = '0; acc_smm = 1'b0; acc_bytes = 3'd4;
        m_ctl = 8'h00; m_ectl = 8'h00; m_x = (EXTM != 0) ? 16'hFFFF : 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 4; a++) rd_check(2'(a), "R1");
        probe(32'h000A_0000, 1'b0, 3'd4, "R4");
        probe(TOP - 1, 1'b0, 3'd4, "R11");

        // R2 masked bits
        wr(2'd0, 8'hF8); rd_check(2'd0, "R2");
        wr(2'd1, 8'h78); rd_check(2'd1, "R2");

        // R4/R5/R6 directed over all open/high/global combinations
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, {5'b0, c[2], 1'b0, c[0]});
            wr(2'd1, {c[1], 7'b0});
            probe(32'h000A_0000, 1'b0, 3'd2, "R4");
            probe(32'h000B_FFFF, 1'b0, 3'd2, "R4");
            probe(32'h000C_0000, 1'b0, 3'd2, "R11");
            probe(32'hFEDA_0000, 1'b0, 3'd2, "R5");
            probe(32'hFEDB_FFFF, 1'b0, 3'd2, "R5");
            probe(32'hFEDC_0000, 1'b0, 3'd2, "R11");
            probe(32'h000A_1000, 1'b1, 3'd1, "R6");
            probe(32'hFEDA_1000, 1'b1, 3'd1, "R6");
        end

        // R7/R8 each size code, floor edges both views
        for (int code = 0; code < 4; code++) begin
            longint sz;
            wr(2'd1, {5'b0, 2'(code), 1'b1});
            sz = longint'(size_mib()) * 1048576;
            probe(32'(longint'(TOP) - sz), 1'b0, 3'd4, "R7");
            probe(32'(longint'(TOP) - sz - 1), 1'b0, 3'd4, "R7");
            probe(32'(longint'(TOP) - sz), 1'b1, 3'd4, "R8");
            probe(TOP - 1, 1'b0, 3'd1, "R8");
            probe(TOP, 1'b0, 3'd1, "R11");
        end
        wr(2'd1, 8'h04);
        probe(TOP - 1, 1'b0, 3'd4, "R7");

        // R9 illegal hole sizes
        wr(2'd1, 8'h01);
        probe(TOP - 16, 1'b0, 3'd0, "R9");
        probe(TOP - 16, 1'b0, 3'd5, "R9");
        probe(TOP - 16, 1'b1, 3'd0, "R9");

        // R10 query handshake and plain stores
        wr(2'd2, 8'h34); wr(2'd3, 8'h12);
        rd_check(2'd2, "R10"); rd_check(2'd3, "R10");
        wr(2'd3, 8'hFF); wr(2'd2, 8'hFF);
        rd_check(2'd2, "R10"); rd_check(2'd3, "R10");

        random_phase(250, 1'b0);

        // R3 lock with open in the same write
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h07);
        rd_check(2'd0, "R3");
        wr(2'd0, 8'h05); rd_check(2'd0, "R3");
        wr(2'd1, 8'h07); rd_check(2'd1, "R3");
        probe(32'h000A_0000, 1'b0, 3'd4, "R3");
        probe(32'hFEDA_0000, 1'b0, 3'd4, "R3");
        probe(32'hFEDA_0000, 1'b1, 3'd4, "R3");
        wr(2'd2, 8'h55); rd_check(2'd2, "R10");

        random_phase(60, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule